// File: doc/BRIEF.md
# Serial Receive Word Buffer

This block is the receive half of one synchronous serial port channel. Serial data is taken on each rising edge of an incoming serial clock, most significant bit first, while the port is enabled. When the last bit of a word arrives, the assembled word goes straight into a two-slot holding store. The store keeps two complete words while a third is still being shifted in.

A host takes words through a valid/ready read port. `rd_valid` is high whenever the store holds a word, and `rd_data` then shows the oldest word. A transfer happens on a clock edge where `rd_valid` and `rd_en` are both high. `rd_en` is the host's ready: if it is raised while the store is empty, the read waits (`rd_stall` high) and completes on the first cycle a word is present. The host never receives stale data. A two-bit occupancy code lets software check the fill level before it reads.

If a third word completes while both slots are full and no read happens on that edge, the new word replaces the newer stored word. The oldest word is kept, and a sticky overflow flag is set on that same edge. Only dropping the port enable clears the flag. Dropping the enable also empties the store and discards any partly received word within one clock.

Top module: `serial_rx_buffer`

## Requirements
- R1: While `port_en` is high, `ser_data` is sampled on each rising edge of `ser_clk` (seen as `ser_clk` high in a `clk` cycle after a cycle with it low). Bits fill the word most significant bit first. After 32 such bits, the word enters the store on that same `clk` edge, without any host action.
- R2: Words are delivered in arrival order. `rd_data` shows the oldest stored word whenever `rd_valid` is high, and one word is removed on each edge where `rd_valid` and `rd_en` are both high.
- R3: `buf_occ` encodes occupancy as 2'b00 for empty, 2'b01 for one word and 2'b11 for two words. The value 2'b10 never appears.
- R4: When a word completes with two words stored and no read on that edge, the new word replaces the second stored word. The first stored word stays unchanged, `buf_occ` stays 2'b11, and `ovf_err` goes high on that edge.
- R5: `ovf_err` is sticky. Host reads never clear it, and it stays high while `port_en` stays high.
- R6: While the store is empty, `rd_en` high gives `rd_stall` high and `rd_valid` low, and nothing is removed. The waiting read completes with the first word that arrives.
- R7: A read and a word completion on the same edge lose no word. With one word stored, the new word becomes the only entry (`buf_occ` 2'b01). With two stored, the oldest leaves, the new word is appended, `buf_occ` stays 2'b11 and `ovf_err` is not set.
- R8: On the first `clk` edge with `port_en` low, the store empties, the partial word and bit count are discarded, and `ovf_err` clears. Serial bits that arrive while `port_en` is low are ignored.
- R9: After synchronous reset (`rst` high), `buf_occ` is 2'b00, `ovf_err`, `rd_valid` and `rd_stall` are low, and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| port_en | input | 1 | Port enable; low clears store, shifter and error flag |
| ser_clk | input | 1 | Serial bit clock, synchronous to `clk`, edge-detected |
| ser_data | input | 1 | Serial data bit, sampled on `ser_clk` rising |
| rd_en | input | 1 | Host ready / read request |
| rd_valid | output | 1 | Store holds a word; `rd_data` is meaningful |
| rd_data | output | 32 | Oldest stored word |
| rd_stall | output | 1 | Read requested while the store is empty |
| buf_occ | output | 2 | Occupancy code: 00 empty, 01 one, 11 two |
| ovf_err | output | 1 | Sticky overflow error |

## Verification
The hardest case to reach is a word finishing on the very edge where the host pops, because the last serial bit and the read request must land on the same `clk` edge. The bench drives `rd_en` in the same cycle as the final `ser_clk` high phase, once with one word stored and once with two. A sweep over 0 to 4 words sent before any read covers every fill level and repeated overflow. The expected contents are computed as the first word plus the most recent one.

// File: rtl/srb_pkg.sv
package srb_pkg;

  typedef enum logic [1:0] {
    OCC_EMPTY = 2'b00,
    OCC_ONE   = 2'b01,
    OCC_FULL  = 2'b11
  } occ_e;

  function automatic occ_e occ_code(input logic [1:0] fill);
    case (fill)
      2'd0:    occ_code = OCC_EMPTY;
      2'd1:    occ_code = OCC_ONE;
      default: occ_code = OCC_FULL;
    endcase
  endfunction

endpackage

// File: rtl/srb_edge.sv
module srb_edge (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sclk,
  output logic rise
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk;
  end

  assign rise = en & sclk & ~sclk_q;

  assert_rise_single_R1: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/srb_shifter.sv
module srb_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              bit_tick,
  input  logic              bit_in,
  output logic              word_done,
  output logic [WORD_W-1:0] word_out
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic [WORD_W-2:0] sreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              at_last;

  assign at_last   = (bit_cnt == LAST_IDX);
  assign word_done = en & bit_tick & at_last;
  assign word_out  = {sreg, bit_in};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sreg    <= '0;
      bit_cnt <= '0;
    end else if (bit_tick) begin
      sreg    <= {sreg[WORD_W-3:0], bit_in};
      bit_cnt <= at_last ? '0 : bit_cnt + 1'b1;
    end
  end

  assert_count_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    word_done |=> (bit_cnt == '0));
  assert_count_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (bit_cnt == '0));
  assert_count_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (en && !bit_tick && $past(en)) |=> $stable(bit_cnt));
endmodule

// File: rtl/srb_hold_buf.sv
module srb_hold_buf #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_stall,
  output logic [1:0]        fill,
  output logic              ovf
);
  logic [WORD_W-1:0] slot0, slot1;
  logic              pop;

  assign rd_valid = (fill != 2'd0);
  assign pop      = rd_en & rd_valid;
  assign rd_stall = rd_en & ~rd_valid;
  assign rd_data  = slot0;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      slot0 <= '0;
      slot1 <= '0;
      fill  <= 2'd0;
      ovf   <= 1'b0;
    end else begin
      case ({push, pop})
        2'b01: begin
          slot0 <= slot1;
          fill  <= fill - 2'd1;
        end
        2'b10: begin
          if (fill == 2'd0) begin
            slot0 <= push_word;
            fill  <= 2'd1;
          end else if (fill == 2'd1) begin
            slot1 <= push_word;
            fill  <= 2'd2;
          end else begin
            slot1 <= push_word;
            ovf   <= 1'b1;
          end
        end
        2'b11: begin
          if (fill == 2'd1) begin
            slot0 <= push_word;
          end else begin
            slot0 <= slot1;
            slot1 <= push_word;
          end
        end
        default: ;
      endcase
    end
  end

  assert_fill_legal_R3: assert property (@(posedge clk) disable iff (rst)
    fill != 2'd3);
  assert_overwrite_head_R4: assert property (@(posedge clk) disable iff (rst)
    (en && push && !pop && fill == 2'd2) |=> ($stable(slot0) && ovf && fill == 2'd2));
  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (ovf && en) |=> ovf);
  assert_ovf_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(push && !pop && fill == 2'd2));
  assert_stall_no_pop_R6: assert property (@(posedge clk) disable iff (rst)
    (en && rd_stall && !push) |=> (fill == 2'd0));
  assert_both_no_ovf_R7: assert property (@(posedge clk) disable iff (rst)
    (en && push && pop && !ovf) |=> (!ovf && fill == $past(fill)));
  assert_disable_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (fill == 2'd0 && !ovf));
endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_stall,
  output logic [1:0]        buf_occ,
  output logic              ovf_err
);
  import srb_pkg::*;

  logic              bit_tick;
  logic              word_done;
  logic [WORD_W-1:0] word_bus;
  logic [1:0]        fill;

  srb_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .en   (port_en),
    .sclk (ser_clk),
    .rise (bit_tick)
  );

  srb_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .en        (port_en),
    .bit_tick  (bit_tick),
    .bit_in    (ser_data),
    .word_done (word_done),
    .word_out  (word_bus)
  );

  srb_hold_buf #(.WORD_W(WORD_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .en        (port_en),
    .push      (word_done),
    .push_word (word_bus),
    .rd_en     (rd_en),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_stall  (rd_stall),
    .fill      (fill),
    .ovf       (ovf_err)
  );

  assign buf_occ = occ_code(fill);

  assert_valid_matches_occ_R3: assert property (@(posedge clk) disable iff (rst)
    rd_valid == (buf_occ != 2'b00));
endmodule

// File: tb/sim_serial_rx_buffer.sv
module sim_serial_rx_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_en = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_data = 1'b0;
  logic rd_en = 1'b0;
  logic rd_valid, rd_stall, ovf_err;
  logic [W-1:0] rd_data;
  logic [1:0] buf_occ;

  int n_checks = 0;
  int n_errors = 0;

  serial_rx_buffer #(.WORD_W(W)) u0 (
    .clk(clk), .rst(rst), .port_en(port_en), .ser_clk(ser_clk),
    .ser_data(ser_data), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_stall(rd_stall), .buf_occ(buf_occ),
    .ovf_err(ovf_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] pat(input int k);
    pat = 32'hA5C3_0F1E ^ (32'(k + 1) * 32'h0102_0409);
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_word(input logic [W-1:0] w, input bit rd_last);
    for (int i = W - 1; i >= 0; i--) begin
      @(negedge clk);
      ser_clk  = 1'b1;
      ser_data = w[i];
      if (i == 0 && rd_last) rd_en = 1'b1;
      @(negedge clk);
      ser_clk = 1'b0;
      if (i == 0 && rd_last) rd_en = 1'b0;
    end
    #1;
  endtask

  task automatic read_word(input string req, input logic [W-1:0] exp);
    @(negedge clk);
    rd_en = 1'b1;
    #1;
    check(req, {31'd0, rd_valid}, 32'd1);
    check(req, rd_data, exp);
    @(negedge clk);
    rd_en = 1'b0;
    #1;
  endtask

  task automatic cycle_disable();
    @(negedge clk);
    port_en = 1'b0;
    @(negedge clk);
    #1;
    check("R8 occ", {30'd0, buf_occ}, 32'd0);
    check("R8 ovf", {31'd0, ovf_err}, 32'd0);
    check("R8 valid", {31'd0, rd_valid}, 32'd0);
    port_en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R9 reset state
    check("R9 occ", {30'd0, buf_occ}, 32'd0);
    check("R9 ovf", {31'd0, ovf_err}, 32'd0);
    check("R9 valid", {31'd0, rd_valid}, 32'd0);
    check("R9 stall", {31'd0, rd_stall}, 32'd0);
    check("R9 data", rd_data, 32'd0);
    port_en = 1'b1;

    // Sweep: send n words, then drain. R1 R2 R3 R4 R5
    for (int n = 0; n <= 4; n++) begin
      for (int k = 0; k < n; k++) send_word(pat(10 * n + k), 1'b0);
      check("R3 occ after fill", {30'd0, buf_occ},
            (n == 0) ? 32'd0 : (n == 1) ? 32'd1 : 32'd3);
      check("R4 ovf after fill", {31'd0, ovf_err}, (n >= 3) ? 32'd1 : 32'd0);
      if (n >= 1) read_word("R1 R2 first word", pat(10 * n));
      if (n >= 2) read_word("R4 second slot holds latest", pat(10 * n + n - 1));
      check("R2 drained", {30'd0, buf_occ}, 32'd0);
      check("R5 sticky after reads", {31'd0, ovf_err}, (n >= 3) ? 32'd1 : 32'd0);
      cycle_disable();
    end

    // R6 stall on empty, then waiting read completes
    @(negedge clk);
    rd_en = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R6 stall", {31'd0, rd_stall}, 32'd1);
    check("R6 no valid", {31'd0, rd_valid}, 32'd0);
    check("R6 occ", {30'd0, buf_occ}, 32'd0);
    send_word(pat(50), 1'b0);
    check("R6 valid after arrival", {31'd0, rd_valid}, 32'd1);
    check("R6 data", rd_data, pat(50));
    @(negedge clk);
    #1;
    check("R6 popped", {30'd0, buf_occ}, 32'd0);
    rd_en = 1'b0;

    // R7 simultaneous read and push with one stored
    send_word(pat(60), 1'b0);
    send_word(pat(61), 1'b1);
    check("R7 occ one", {30'd0, buf_occ}, 32'd1);
    read_word("R7 one-stored", pat(61));

    // R7 simultaneous read and push with two stored
    send_word(pat(70), 1'b0);
    send_word(pat(71), 1'b0);
    send_word(pat(72), 1'b1);
    check("R7 occ full", {30'd0, buf_occ}, 32'd3);
    check("R7 no ovf", {31'd0, ovf_err}, 32'd0);
    read_word("R7 order a", pat(71));
    read_word("R7 order b", pat(72));

    // R8 bits ignored while disabled
    @(negedge clk);
    port_en = 1'b0;
    send_word(pat(80), 1'b0);
    check("R8 ignored", {30'd0, buf_occ}, 32'd0);
    port_en = 1'b1;

    // R8 partial word discarded by disable
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); ser_clk = 1'b1; ser_data = i[0];
      @(negedge clk); ser_clk = 1'b0;
    end
    cycle_disable();
    send_word(pat(90), 1'b0);
    read_word("R8 partial discarded", pat(90));

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule